// File: doc/BRIEF.md
# Floating-Point Pipeline Issue Controller

This block governs when operations may enter a three-stage floating-point execution pipeline, and when each one finishes. Dispatch offers one operation per cycle on a valid/ready port. Each offer carries a 3-bit operation class and a tag. The block performs no arithmetic. It tracks which completion slots are occupied and runs a countdown for long or serialising operations. After the latency of its class, it reports each accepted tag on a completion port.

Ordinary operations are pipelined, so a new one may enter on every cycle. Divides and status-register moves are serialising. Such an operation enters only into an empty pipeline. Once it is inside, it locks out every other issue until it has finished. A synchronous flush discards all work in flight.

Top module: `fp_issue_ctl`

## Requirements
- R1: After reset, with no flush and no work in flight, `iss_ready` is high for every class and `cmp_valid` is low.
- R2: Timing convention for all classes: an operation accepted at clock edge k with latency L shows `cmp_valid` high during the cycle after edge k+L-1, and only then. Class 0 has L=3. Classes 5, 6 and 7 behave exactly like class 0.
- R3: Class 1 is a pipelined operation with L=4.
- R4: Pipelined classes (0, 1, 5, 6, 7) may be accepted on consecutive cycles. A 3-cycle class is refused in the cycle directly after a class 1 acceptance, so that completions stay in issue order with at most one per cycle.
- R5: Class 2 (single divide) has L=17. Class 3 (double divide) has L=31.
- R6: Class 4 (status-register move) has L=3 and is serialising.
- R7: While a serialising operation (classes 2, 3, 4) is in flight, up to and including its completion cycle, `iss_ready` is low for every class. It is high again in the following cycle.
- R8: A serialising operation is refused while any pipelined operation is still waiting for its completion cycle.
- R9: While `flush` is high, `iss_ready` is low. The edge on which `flush` is high discards all in-flight work and any countdown, so no completion appears afterwards until new work is accepted.
- R10: `cmp_tag` equals the tag given at acceptance for the operation that is completing. Completions appear in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous discard of all in-flight work |
| iss_valid | input | 1 | Dispatch offers an operation |
| iss_cls | input | 3 | Operation class code |
| iss_tag | input | TAG_W | Tag of the offered operation |
| iss_ready | output | 1 | Offer will be accepted this cycle (depends on `iss_cls`) |
| cmp_valid | output | 1 | An operation completes this cycle |
| cmp_tag | output | TAG_W | Tag of the completing operation |

## Verification
A wrong slot bit or countdown value appears at the ports as a completion in the wrong cycle or with the wrong tag. It can also appear as a ready level that differs from the one implied by the work accepted so far. The bench predicts both every cycle, so a fault is reported in the first cycle it becomes visible. For a divide, that is at most 31 cycles after acceptance. The sweep covers every ordered pair of classes at issue gaps of zero to three cycles, which drives each refusal rule, including the one-cycle refusal after a 4-cycle operation. Flushes placed in the middle of serialising and pipelined work show whether any leftover state survives.

// File: rtl/fp_issue_ctl.sv
module fp_issue_ctl #(
  parameter int TAG_W    = 4,
  parameter int SDIV_CYC = 17,
  parameter int DDIV_CYC = 31,
  parameter int FSR_CYC  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             iss_valid,
  input  logic [2:0]       iss_cls,
  input  logic [TAG_W-1:0] iss_tag,
  output logic             iss_ready,
  output logic             cmp_valid,
  output logic [TAG_W-1:0] cmp_tag
);
  localparam int MAXL  = (SDIV_CYC > DDIV_CYC) ? ((SDIV_CYC > FSR_CYC) ? SDIV_CYC : FSR_CYC)
                                               : ((DDIV_CYC > FSR_CYC) ? DDIV_CYC : FSR_CYC);
  localparam int CW    = $clog2(MAXL + 1);
  localparam int DEPTH = 4;

  logic [DEPTH:1]   pv;
  logic [TAG_W-1:0] pt [1:DEPTH];
  logic [CW-1:0]    bcnt;
  logic [CW-1:0]    blat;
  logic [TAG_W-1:0] btag;
  logic             is_blk;
  logic             is_long;
  logic             take;

  always_comb begin
    case (iss_cls)
      3'd2:    blat = CW'(SDIV_CYC);
      3'd3:    blat = CW'(DDIV_CYC);
      3'd4:    blat = CW'(FSR_CYC);
      default: blat = '0;
    endcase
  end

  assign is_blk    = (iss_cls == 3'd2) || (iss_cls == 3'd3) || (iss_cls == 3'd4);
  assign is_long   = (iss_cls == 3'd1);
  assign iss_ready = !flush && (bcnt == '0) &&
                     (is_blk ? (pv == '0) : (is_long || !pv[DEPTH]));
  assign take      = iss_valid && iss_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv   <= '0;
      bcnt <= '0;
      btag <= '0;
      for (int k = 1; k <= DEPTH; k++) pt[k] <= '0;
    end else if (flush) begin
      pv   <= '0;
      bcnt <= '0;
    end else begin
      for (int k = 1; k <= DEPTH - 2; k++) begin
        pv[k] <= pv[k+1];
        pt[k] <= pt[k+1];
      end
      pv[DEPTH-1] <= pv[DEPTH] | (take & !is_blk & !is_long);
      pt[DEPTH-1] <= pv[DEPTH] ? pt[DEPTH] : iss_tag;
      pv[DEPTH]   <= take & is_long;
      pt[DEPTH]   <= iss_tag;
      if (take && is_blk) begin
        bcnt <= blat;
        btag <= iss_tag;
      end else if (bcnt != '0) begin
        bcnt <= bcnt - 1'b1;
      end
    end
  end

  assign cmp_valid = pv[1] | (bcnt == CW'(1));
  assign cmp_tag   = pv[1] ? pt[1] : btag;
endmodule

module fp_issue_ctl_chk #(
  parameter int CW       = 5,
  parameter int DDIV_CYC = 31
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          iss_valid,
  input logic          iss_ready,
  input logic [2:0]    iss_cls,
  input logic          cmp_valid,
  input logic [4:1]    pv,
  input logic [CW-1:0] bcnt
);
  logic acc;
  assign acc = iss_valid && iss_ready;

  // R7
  busy_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bcnt != '0) |-> !iss_ready);

  // R8
  blk_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (iss_cls == 3'd2 || iss_cls == 3'd3 || iss_cls == 3'd4)) |-> (pv == '0));

  // R10
  one_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pv[1] && bcnt == CW'(1)));

  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!cmp_valid && pv == '0 && bcnt == '0));

  // R5
  ddiv_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !flush && iss_cls == 3'd3) |=> (bcnt == CW'(DDIV_CYC)));

  // R4
  long_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !flush && iss_cls == 3'd1) |=> pv[4]);
endmodule

bind fp_issue_ctl fp_issue_ctl_chk #(.CW(CW), .DDIV_CYC(DDIV_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .iss_valid(iss_valid),
  .iss_ready(iss_ready), .iss_cls(iss_cls), .cmp_valid(cmp_valid),
  .pv(pv), .bcnt(bcnt)
);

// File: tb/fp_issue_ctl_bench.sv
module fp_issue_ctl_bench;
  localparam int NCYC = 16384;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flush = 1'b0;
  logic       iss_valid = 1'b0;
  logic [2:0] iss_cls = 3'd0;
  logic [3:0] iss_tag = 4'd0;
  logic       iss_ready;
  logic       cmp_valid;
  logic [3:0] cmp_tag;

  fp_issue_ctl u_fp_issue_ctl (
    .clk(clk), .rst_n(rst_n), .flush(flush), .iss_valid(iss_valid),
    .iss_cls(iss_cls), .iss_tag(iss_tag), .iss_ready(iss_ready),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag)
  );

  always #5 clk = ~clk;

  int   total = 0;
  int   bad = 0;
  int   cyc = 0;
  bit   done = 0;
  bit   ev [NCYC];
  logic [3:0] et [NCYC];
  logic [2:0] ec [NCYC];
  int   last_pipe = -1;
  int   blk_end = -1;
  int   long_edge = -1;
  logic [3:0] next_tag = 4'd0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int lat_of(input logic [2:0] c);
    case (c)
      3'd1: return 4;
      3'd2: return 17;
      3'd3: return 31;
      default: return 3;
    endcase
  endfunction

  function automatic bit blk_of(input logic [2:0] c);
    return (c == 3'd2) || (c == 3'd3) || (c == 3'd4);
  endfunction

  function automatic string req_of(input logic [2:0] c);
    case (c)
      3'd1: return "R3";
      3'd2, 3'd3: return "R5";
      3'd4: return "R6";
      default: return "R2";
    endcase
  endfunction

  always @(negedge clk) begin
    if (!done && cyc < NCYC - 64) begin
      bit    er;
      string rq;
      total++;
      if (cmp_valid !== ev[cyc]) begin
        bad++;
        $display("FAIL %s cycle %0d cmp_valid=%b expected %b", req_of(ec[cyc]), cyc, cmp_valid, ev[cyc]);
      end
      if (ev[cyc]) begin
        total++;
        if (cmp_tag !== et[cyc]) begin
          bad++;
          $display("FAIL R10 cycle %0d cmp_tag=%0d expected %0d", cyc, cmp_tag, et[cyc]);
        end
      end
      if (flush) begin
        er = 0; rq = "R9";
      end else if (cyc <= blk_end) begin
        er = 0; rq = "R7";
      end else if (blk_of(iss_cls)) begin
        er = (cyc > last_pipe); rq = "R8";
      end else if (iss_cls != 3'd1 && long_edge == cyc) begin
        er = 0; rq = "R4";
      end else begin
        er = 1; rq = "R1";
      end
      total++;
      if (iss_ready !== er) begin
        bad++;
        $display("FAIL %s cycle %0d iss_ready=%b expected %b cls=%0d", rq, cyc, iss_ready, er, iss_cls);
      end
      if (rst_n && iss_valid && iss_ready) begin
        int n;
        int e;
        n = cyc + 1;
        e = n + lat_of(iss_cls) - 1;
        ev[e] = 1;
        et[e] = iss_tag;
        ec[e] = iss_cls;
        if (blk_of(iss_cls)) blk_end = e;
        else last_pipe = e;
        if (iss_cls == 3'd1) long_edge = n;
      end
      if (flush) begin
        for (int i = cyc + 1; i < cyc + 40; i++) ev[i] = 0;
        last_pipe = -1;
        blk_end = -1;
        long_edge = -1;
      end
    end
  end

  task automatic issue(input logic [2:0] c);
    bit ok;
    iss_valid = 1'b1;
    iss_cls = c;
    iss_tag = next_tag;
    next_tag = next_tag + 4'd1;
    do begin
      @(negedge clk);
      ok = iss_ready;
      @(posedge clk);
      #1;
    end while (!ok);
    iss_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic do_flush();
    flush = 1'b1;
    idle(1);
    flush = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < NCYC; i++) begin
      ev[i] = 0; et[i] = '0; ec[i] = '0;
    end
    idle(3);
    rst_n = 1'b1;
    idle(1);
    @(negedge clk);
    total++;
    if (iss_ready !== 1'b1 || cmp_valid !== 1'b0) begin
      bad++;
      $display("FAIL R1 after reset ready=%b valid=%b expected 1 0", iss_ready, cmp_valid);
    end
    @(posedge clk); #1;
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        for (int g = 0; g < 4; g++) begin
          issue(3'(a));
          idle(g);
          issue(3'(b));
          idle(34);
        end
    for (int k = 0; k < 24; k++) issue(3'(k % 3 == 0 ? 1 : 0));
    idle(8);
    for (int c = 0; c < 8; c++) begin
      issue(3'(c));
      idle(1);
      do_flush();
      idle(34);
    end
    issue(3'd1); issue(3'd0); issue(3'd0);
    do_flush();
    issue(3'd3);
    idle(35);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    done = 1;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule